// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block buffers 18-bit words between a producer clocked by `wclk` and a consumer clocked by `rclk`. It holds 4096 words. Write and read enables are active low. Status comes out on five active-low flags:

- empty, updated in the read domain;
- full, updated in the write domain;
- half-full, updated in the write domain;
- almost-empty and almost-full, each set by its own programmable threshold.

The write and read pointers cross between the domains in Gray code through two-flop synchronizers. For that reason the flags react to the far side's activity a few cycles late. The delay always errs towards reporting less data to the reader and less space to the writer.

The two thresholds are loaded and read back through the normal data ports while `load_n` is held low. Successive load-mode writes fill the almost-empty offset first and then the almost-full offset, and the order then repeats. Load-mode reads return the two offsets in the same alternating order.

`sync_mode` chooses how the almost flags behave. They can be registered in their own domains, or they can follow the synchronized pointers combinationally. A `rewind` pulse returns the read pointer to the first location written since reset, so that the data is read out again. The data output is tri-stated by `oe_n`.

Top module: `twoclk_fifo_pf`

## Requirements
- R1: With `load_n` high, a rising `wclk` edge with `wr_n` low and `full_n` high stores `din`. Stored words are delivered on `dout` in the order they were written.
- R2: With `load_n` high, a rising `rclk` edge with `rd_n` low and `empty_n` high places the oldest word on `dout`, which is registered. A read while `empty_n` is low leaves `dout` and the contents unchanged.
- R3: `full_n` is registered on `wclk` and goes low when 4096 words are held. Writes while `full_n` is low are dropped, so exactly 4096 words are read back.
- R4: `empty_n` is registered on `rclk`. It is low after reset and goes high only after a written word has passed the two-flop pointer synchronizer.
- R5: While `load_n` is low, each enabled `wclk` edge stores `din[11:0]` alternately into the almost-empty offset and then the almost-full offset. Nothing is stored into the buffer.
- R6: While `load_n` is low, each enabled `rclk` edge puts an offset on `dout[11:0]`, alternating between the almost-empty and almost-full offsets, with bits 17:12 at zero. The read pointer does not move.
- R7: `aempty_n` is low exactly when the word count seen by the read domain is at or below the almost-empty offset.
- R8: `afull_n` is low exactly when the free space seen by the write domain (4096 minus the count) is at or below the almost-full offset.
- R9: With `sync_mode` = 1 the almost flags are registered on their own clocks from the post-edge pointer. With `sync_mode` = 0 they follow the current synchronized pointers and offsets combinationally.
- R10: `half_n` is registered on `wclk` and is low exactly when the write-domain count exceeds 2048.
- R11: A `rewind` high at a rising `rclk` edge sets the read pointer to the first location, and any read requested in that cycle is ignored. Words written since reset are then delivered again from the first one.
- R12: With `oe_n` high, `dout` is high impedance. With `oe_n` low, `dout` drives the output register.
- R13: Reset (`rst_n` low, asynchronous) empties the buffer. It drives `empty_n` and `aempty_n` low and `full_n`, `afull_n` and `half_n` high, sets both offsets to 7, and points both load sequencers at the almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Read enable, active low |
| load_n | input | 1 | Offset load/readback strobe, active low |
| rewind | input | 1 | Retransmit pulse, read domain |
| sync_mode | input | 1 | 1: registered almost flags, 0: combinational |
| oe_n | input | 1 | Output enable, active low |
| din | input | 18 | Write data / offset value |
| dout | output | 18 | Read data / offset readback, tri-stated |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |

## Verification
The assertions assume a few things about the inputs:

- all inputs are known once reset is released;
- `rewind` is used only while no more than 4096 words have been written since reset, so rewinding cannot produce a count larger than the storage.

The stimulus drives both clocks from a single source, so that the synchronizer latency is fixed and can be modelled. It applies a reset before the retransmit phase, so the rewind always lands inside the words written since that reset. Offsets are reloaded only in cycles where the flags are then compared against the new value in the same way the model sees it.

// File: rtl/twoclk_fifo_pf.sv
module twoclk_fifo_pf #(
  parameter int W       = 18,
  parameter int AW      = 12,
  parameter int OFS_RST = 7
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic         load_n,
  input  logic         rewind,
  input  logic         sync_mode,
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty_n,
  output logic         full_n,
  output logic         aempty_n,
  output logic         afull_n,
  output logic         half_n
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  typedef logic [PW-1:0] ptr_t;
  localparam ptr_t DEPTH_P = ptr_t'(DEPTH);
  localparam ptr_t HALF_P  = ptr_t'(DEPTH / 2);

  function automatic ptr_t g2b(input ptr_t g);
    ptr_t b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] aeofs, afofs;
  logic wsel, rsel;

  // write domain
  ptr_t wbin, wgray, rq1, rq2, rq2b, wbin_nx, wcount, wcount_nx;
  logic push, full_r, afull_s, half_r;

  assign push      = !wr_n && load_n && full_r;
  assign wbin_nx   = wbin + {{AW{1'b0}}, push};
  assign rq2b      = g2b(rq2);
  assign wcount    = wbin - rq2b;
  assign wcount_nx = wbin_nx - rq2b;

  // read domain
  ptr_t rbin, rgray, wq1, wq2, wq2b, rbin_nx, rcount;
  logic pop, empty_r, aempty_s;
  logic [W-1:0] q_r;

  assign pop     = !rd_n && load_n && empty_r && !rewind;
  assign rbin_nx = rewind ? '0 : rbin + {{AW{1'b0}}, pop};
  assign wq2b    = g2b(wq2);
  assign rcount  = wq2b - rbin;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rq1     <= '0;
      rq2     <= '0;
      full_r  <= 1'b1;
      afull_s <= 1'b1;
      half_r  <= 1'b1;
      aeofs   <= AW'(OFS_RST);
      afofs   <= AW'(OFS_RST);
      wsel    <= 1'b0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wbin_nx ^ (wbin_nx >> 1);
      rq1     <= rgray;
      rq2     <= rq1;
      full_r  <= wcount_nx != DEPTH_P;
      afull_s <= !((DEPTH_P - wcount_nx) <= {1'b0, afofs});
      half_r  <= !(wcount_nx > HALF_P);
      if (!wr_n && !load_n) begin
        if (wsel) afofs <= din[AW-1:0];
        else      aeofs <= din[AW-1:0];
        wsel <= !wsel;
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= din;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wq1      <= '0;
      wq2      <= '0;
      empty_r  <= 1'b0;
      aempty_s <= 1'b0;
      q_r      <= '0;
      rsel     <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      wq1      <= wgray;
      wq2      <= wq1;
      empty_r  <= wq2b != rbin_nx;
      aempty_s <= !((wq2b - rbin_nx) <= {1'b0, aeofs});
      if (pop) begin
        q_r <= mem[rbin[AW-1:0]];
      end else if (!rd_n && !load_n) begin
        q_r  <= {{(W-AW){1'b0}}, rsel ? afofs : aeofs};
        rsel <= !rsel;
      end
    end
  end

  assign dout     = oe_n ? {W{1'bz}} : q_r;
  assign empty_n  = empty_r;
  assign full_n   = full_r;
  assign half_n   = half_r;
  assign aempty_n = sync_mode ? aempty_s : !(rcount <= {1'b0, aeofs});
  assign afull_n  = sync_mode ? afull_s : !((DEPTH_P - wcount) <= {1'b0, afofs});
endmodule

// File: rtl/twoclk_fifo_pf_chk.sv
module twoclk_fifo_pf_chk #(
  parameter int AW = 12
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        wr_n,
  input logic        rd_n,
  input logic        load_n,
  input logic        rewind,
  input logic        full_n,
  input logic        empty_n,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin,
  input logic [AW:0] wcount
);
  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wr_n) |=> $stable(wbin));

  a_r3_count_bound: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= {1'b1, {AW{1'b0}}});

  a_r5_load_no_store: assert property (@(posedge wclk) disable iff (!rst_n)
    !load_n |=> $stable(wbin));

  a_r2_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && !rewind) |=> $stable(rbin));

  a_r6_readback_no_pop: assert property (@(posedge rclk) disable iff (!rst_n)
    (!load_n && !rd_n && !rewind) |=> $stable(rbin));

  a_r11_rewind_start: assert property (@(posedge rclk) disable iff (!rst_n)
    rewind |=> (rbin == '0));
endmodule

bind twoclk_fifo_pf twoclk_fifo_pf_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
  .load_n(load_n), .rewind(rewind), .full_n(full_n), .empty_n(empty_n),
  .wbin(wbin), .rbin(rbin), .wcount(wcount)
);

// File: tb/tb_twoclk_fifo_pf.sv
`timescale 1ns/1ps
module tb_twoclk_fifo_pf;
  logic clk = 0, rst_n = 0;
  logic wr_n = 1, rd_n = 1, load_n = 1, rewind = 0, sync_mode = 1, oe_n = 0;
  logic [17:0] din = '0;
  wire  [17:0] dout;
  wire  empty_n, full_n, aempty_n, afull_n, half_n;

  always #2 clk = ~clk;

  twoclk_fifo_pf dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
    .load_n(load_n), .rewind(rewind), .sync_mode(sync_mode), .oe_n(oe_n),
    .din(din), .dout(dout), .empty_n(empty_n), .full_n(full_n),
    .aempty_n(aempty_n), .afull_n(afull_n), .half_n(half_n)
  );

  int ntest = 0, nfail = 0;
  bit done = 0;
  string ph = "R13";

  // behavioural reference
  int mm [4096];
  logic [12:0] m_wp, m_rp, m_rq1, m_rq2, m_wq1, m_wq2;
  bit m_full, m_empty, m_aes, m_afs, m_half, m_wsel, m_rsel;
  int m_q, m_aeo, m_afo;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wp = 0; m_rp = 0; m_rq1 = 0; m_rq2 = 0; m_wq1 = 0; m_wq2 = 0;
      m_full = 1; m_empty = 0; m_aes = 0; m_afs = 1; m_half = 1;
      m_wsel = 0; m_rsel = 0; m_q = 0; m_aeo = 7; m_afo = 7;
    end else begin
      bit push, pop;
      logic [12:0] wpn, rpn;
      int wc, rc;
      push = !wr_n && load_n && m_full;
      pop  = !rd_n && load_n && m_empty && !rewind;
      wpn = m_wp + 13'(push);
      rpn = rewind ? 13'd0 : m_rp + 13'(pop);
      wc = int'(13'(wpn - m_rq2));
      rc = int'(13'(m_wq2 - rpn));
      if (pop) m_q = mm[m_rp[11:0]];
      else if (!rd_n && !load_n) begin
        m_q = m_rsel ? m_afo : m_aeo;
        m_rsel = !m_rsel;
      end
      if (push) mm[m_wp[11:0]] = int'(din);
      m_full  = (wc != 4096);
      m_afs   = !((4096 - wc) <= m_afo);
      m_half  = !(wc > 2048);
      m_empty = (m_wq2 != rpn);
      m_aes   = !(rc <= m_aeo);
      if (!wr_n && !load_n) begin
        if (m_wsel) m_afo = int'(din[11:0]);
        else        m_aeo = int'(din[11:0]);
        m_wsel = !m_wsel;
      end
      m_rq2 = m_rq1; m_rq1 = m_rp; m_wq2 = m_wq1; m_wq1 = m_wp;
      m_wp = wpn; m_rp = rpn;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit aea, afa;
      afa = !((4096 - int'(13'(m_wp - m_rq2))) <= m_afo);
      aea = !(int'(13'(m_wq2 - m_rp)) <= m_aeo);
      chk({"R4 empty ", ph}, int'(empty_n), int'(m_empty));
      chk({"R3 full ", ph},  int'(full_n),  int'(m_full));
      chk({"R10 half ", ph}, int'(half_n),  int'(m_half));
      chk({"R7 R9 aempty ", ph}, int'(aempty_n), int'(sync_mode ? m_aes : aea));
      chk({"R8 R9 afull ", ph},  int'(afull_n),  int'(sync_mode ? m_afs : afa));
      if (oe_n) chk({"R12 hiz ", ph}, int'(dout === 18'bz), 1);
      else      chk({"R1 R2 dout ", ph}, int'(dout), m_q);
    end
  end

  // w: write, r: read, l: load mode, rw: rewind
  task automatic cyc(input bit w, input bit r, input bit l, input bit rw, input int d);
    @(negedge clk); #1;
    wr_n = !w; rd_n = !r; load_n = !l; rewind = rw; din = 18'(d);
  endtask

  function automatic int pat(input int i);
    return (i * 7919 + 12345) & 18'h3ffff;
  endfunction

  task automatic do_reset();
    @(negedge clk); #1;
    wr_n = 1; rd_n = 1; load_n = 1; rewind = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #0.5;
    chk("R13 empty_n", int'(empty_n), 0);
    chk("R13 aempty_n", int'(aempty_n), 0);
    chk("R13 full_n", int'(full_n), 1);
    chk("R13 afull_n", int'(afull_n), 1);
    chk("R13 half_n", int'(half_n), 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    ph = "R13 R6";
    cyc(0, 1, 1, 0, 0); cyc(0, 1, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    ph = "R5 R6";
    cyc(1, 0, 1, 0, 18'h3f004); cyc(1, 0, 1, 0, 10);
    cyc(0, 1, 1, 0, 0); cyc(0, 1, 1, 0, 0); cyc(0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    ph = "R1 R7";
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, pat(i));
    repeat (4) cyc(0, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 0);
    repeat (4) cyc(0, 0, 0, 0, 0);
    ph = "R2 empty read";
    repeat (3) cyc(0, 1, 0, 0, 0);
    ph = "R1 mixed";
    for (int i = 0; i < 40; i++) cyc(i % 3 != 0, i % 2 == 1, 0, 0, pat(i + 100));
    repeat (6) cyc(0, 1, 0, 0, 0);
    ph = "R9 async";
    sync_mode = 0;
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, pat(i + 300));
    cyc(1, 0, 1, 0, 2); cyc(1, 0, 1, 0, 4090);
    for (int i = 0; i < 14; i++) cyc(0, i % 3 == 0, 0, 0, 0);
    repeat (12) cyc(0, 1, 0, 0, 0);
    sync_mode = 1;
    ph = "R3 R8 R10 fill";
    for (int i = 0; i < 4100; i++) cyc(1, 0, 0, 0, pat(i + 1000));
    repeat (5) cyc(0, 0, 0, 0, 0);
    for (int i = 0; i < 4100; i++) cyc(0, 1, 0, 0, 0);
    repeat (5) cyc(0, 0, 0, 0, 0);
    do_reset();
    ph = "R13 R6 after reset";
    cyc(0, 1, 1, 0, 0); cyc(0, 1, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    ph = "R11";
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, pat(i + 9000));
    repeat (4) cyc(0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0);
    cyc(0, 1, 0, 1, 0);
    repeat (4) cyc(0, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 0);
    ph = "R12";
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, pat(i + 500));
    repeat (4) cyc(0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      cyc(0, 1, 0, 0, 0);
      oe_n = (i % 2 == 0);
    end
    oe_n = 0;
    repeat (4) cyc(0, 0, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule